// File: doc/BRIEF.md
# Translation Unit Control and Fault Register File

This block is the software-visible register file that sits beside an I/O address translation unit. A processor reaches it through a single-cycle request port that carries a word index rather than a byte address. Each named register has its own write rule: some bits are masked off, some are forced to one, and the identity register accumulates with a bitwise OR. Any word in the map that has no named register falls through to a small scratch store.

The block drives the translator with three things: the enable bit, the page-table base and the start address of the translated DMA window. The window start is recomputed whenever the control register is written, from that register's 3-bit size code. The translator reports a failed lookup on the capture port. That loads the fault status and fault address registers and raises a level interrupt. Software clears the interrupt by reading or writing either of those two registers.

Top module: `xlat_regfile`

## Requirements
- R1: After reset, the registers read as follows. Control reads {IMPL_VER, 24'h0}. Arbitration enable (word 0x800) reads 0x00000008. Fault status (word 0x400) reads 0x00800000. Arbiter enable (word 0x402) reads 0x00000003. Identity (word 0xC06) reads 0x23000000. Every other register and scratch word reads 0. `win_start`, `tbl_base`, `xlat_en` and `irq` are all 0.
- R2: A write to control (word 0x000) stores (data & 0x1D) with IMPL_VER in bits [31:24]. `xlat_en` follows control bit 0.
- R3: A control write sets `win_start` to 2^32 − 2^(24+c), where c is data bits [4:2]. So c=0 gives 0xFF000000, c=3 gives 0xF8000000 and c=7 gives 0x80000000.
- R4: A write to the table base (word 0x001) keeps only mask 0x07FFFC00, and `tbl_base` shows the stored value. A write to a slot configuration word (0x404..0x407) keeps only mask 0x00010003. The two flush words (0x005, 0x006) store the full 32-bit value.
- R5: A write to arbiter enable keeps mask 0x801F000F and forces bit 0 to 1. A write to arbitration enable keeps mask 0x001F0000 and forces bit 3 to 1.
- R6: A write to fault status keeps mask 0xFF0FFFFF and forces bit 23 to 1. A write to fault address (word 0x401) stores the full value.
- R7: A write to identity ORs (data & 0x00FFFFFF) into the current contents.
- R8: A capture pulse loads fault status and fault address one cycle later and raises `irq`. Fault status becomes 0xC0820000 for a write access or 0xC0860000 for a read access, where bit 18 marks a read. Fault address becomes `flt_addr`.
- R9: Any read or write of fault status or fault address clears `irq` on the next edge. Accesses to other words leave `irq` unchanged.
- R10: A capture in the same cycle as a software access to fault status or fault address wins. The registers take the capture values and `irq` stays set.
- R11: A read request produces `rsp_valid` with the register contents one cycle later. A word with no named register maps to scratch entry (index mod SCRATCH_WORDS). Scratch stores full 32-bit values, so indices that differ by a multiple of SCRATCH_WORDS alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | WIDX_W | Word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| flt_valid | input | 1 | Translation fault capture pulse |
| flt_addr | input | 32 | Faulting page address |
| flt_is_write | input | 1 | Faulting access was a write |
| irq | output | 1 | Level fault interrupt |
| xlat_en | output | 1 | Translation enable (control bit 0) |
| win_start | output | 32 | Start of the translated DMA window |
| tbl_base | output | 32 | Page-table base register |

## Verification
Fault capture and the software access that clears the interrupt can land on the same edge. The bench provokes this by driving a capture pulse in the same cycle as a write to fault status, and again with a read of fault address. It then confirms that `irq` is still high and that the registers read back the capture values, not the software data. It also confirms the normal path: a capture followed by a read in a later cycle does clear the interrupt.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

  typedef enum logic [3:0] {
    SEL_CTRL, SEL_BASE, SEL_TLBF, SEL_PGF, SEL_FSR, SEL_FAR,
    SEL_AER, SEL_SLOT, SEL_ARBEN, SEL_IDENT, SEL_SCRATCH
  } reg_sel_e;

  // word indices (byte offset / 4)
  localparam int IDX_CTRL  = 'h000;
  localparam int IDX_BASE  = 'h001;
  localparam int IDX_TLBF  = 'h005;
  localparam int IDX_PGF   = 'h006;
  localparam int IDX_FSR   = 'h400;
  localparam int IDX_FAR   = 'h401;
  localparam int IDX_AER   = 'h402;
  localparam int IDX_SLOT0 = 'h404;
  localparam int IDX_ARBEN = 'h800;
  localparam int IDX_IDENT = 'hC06;

  localparam logic [31:0] CTRL_KEEP   = 32'h0000_001D;
  localparam logic [31:0] BASE_KEEP   = 32'h07FF_FC00;
  localparam logic [31:0] SLOT_KEEP   = 32'h0001_0003;
  localparam logic [31:0] AER_KEEP    = 32'h801F_000F;
  localparam logic [31:0] AER_SET     = 32'h0000_0001;
  localparam logic [31:0] AER_INIT    = 32'h0000_0003;
  localparam logic [31:0] ARB_KEEP    = 32'h001F_0000;
  localparam logic [31:0] ARB_SET     = 32'h0000_0008;
  localparam logic [31:0] FSR_KEEP    = 32'hFF0F_FFFF;
  localparam logic [31:0] FSR_RSV     = 32'h0080_0000;
  localparam logic [31:0] IDENT_KEEP  = 32'h00FF_FFFF;
  localparam logic [31:0] IDENT_INIT  = 32'h2300_0000;

  localparam logic [31:0] FSR_ERR = 32'h8000_0000;
  localparam logic [31:0] FSR_LE  = 32'h4000_0000;
  localparam logic [31:0] FSR_FAV = 32'h0002_0000;
  localparam logic [31:0] FSR_RD  = 32'h0004_0000;

  // window start: all ones above bit (24+code)
  function automatic logic [31:0] window_of(input logic [2:0] code);
    return 32'hFFFF_FFFF << (5'd24 + {2'b00, code});
  endfunction

  function automatic logic [31:0] fault_word(input logic was_write);
    return FSR_ERR | FSR_LE | FSR_RSV | FSR_FAV | (was_write ? 32'h0 : FSR_RD);
  endfunction

endpackage

// File: rtl/xrf_decode.sv
module xrf_decode
  import xrf_pkg::*;
#(
  parameter int WIDX_W = 12,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [WIDX_W-1:0] word,
  output reg_sel_e          sel,
  output logic [SLOT_W-1:0] slot
);
  logic [WIDX_W-1:0] slot_off;
  assign slot_off = word - WIDX_W'(IDX_SLOT0);
  assign slot     = slot_off[SLOT_W-1:0];

  always_comb begin
    sel = SEL_SCRATCH;
    if      (word == WIDX_W'(IDX_CTRL))  sel = SEL_CTRL;
    else if (word == WIDX_W'(IDX_BASE))  sel = SEL_BASE;
    else if (word == WIDX_W'(IDX_TLBF))  sel = SEL_TLBF;
    else if (word == WIDX_W'(IDX_PGF))   sel = SEL_PGF;
    else if (word == WIDX_W'(IDX_FSR))   sel = SEL_FSR;
    else if (word == WIDX_W'(IDX_FAR))   sel = SEL_FAR;
    else if (word == WIDX_W'(IDX_AER))   sel = SEL_AER;
    else if (word == WIDX_W'(IDX_ARBEN)) sel = SEL_ARBEN;
    else if (word == WIDX_W'(IDX_IDENT)) sel = SEL_IDENT;
    else if (slot_off < WIDX_W'(SLOTS))  sel = SEL_SLOT;
  end
endmodule

// File: rtl/xrf_window.sv
module xrf_window
  import xrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [2:0]  code,
  output logic [31:0] start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    start <= 32'h0;
    else if (load) start <= window_of(code);
  end
endmodule

// File: rtl/xrf_fault.sv
module xrf_fault
  import xrf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_valid,
  input  logic [31:0] cap_addr,
  input  logic        cap_is_write,
  input  logic        fsr_we,
  input  logic        far_we,
  input  logic        touch,
  input  logic [31:0] wdata,
  output logic [31:0] fsr_q,
  output logic [31:0] far_q,
  output logic        irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= FSR_RSV;
      far_q <= 32'h0;
      irq   <= 1'b0;
    end else if (cap_valid) begin
      fsr_q <= fault_word(cap_is_write);
      far_q <= cap_addr;
      irq   <= 1'b1;
    end else begin
      if (fsr_we) fsr_q <= (wdata & FSR_KEEP) | FSR_RSV;
      if (far_we) far_q <= wdata;
      if (touch)  irq   <= 1'b0;
    end
  end
endmodule

// File: rtl/xlat_regfile.sv
module xlat_regfile
  import xrf_pkg::*;
#(
  parameter int         WIDX_W        = 12,
  parameter logic [7:0] IMPL_VER      = 8'h41,
  parameter int         SLOTS         = 4,
  parameter int         SCRATCH_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WIDX_W-1:0] req_word,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              flt_valid,
  input  logic [31:0]       flt_addr,
  input  logic              flt_is_write,
  output logic              irq,
  output logic              xlat_en,
  output logic [31:0]       win_start,
  output logic [31:0]       tbl_base
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int SCR_W  = $clog2(SCRATCH_WORDS);
  localparam logic [31:0] CTRL_INIT = {IMPL_VER, 24'h0};

  reg_sel_e          sel;
  logic [SLOT_W-1:0] slot_idx;
  logic              wr, rd;
  logic              ctrl_we, ident_we, fsr_touch;

  logic [31:0] ctrl_q, base_q, tlbf_q, pgf_q, aer_q, arben_q, ident_q;
  logic [31:0] fsr_q, far_q;
  logic [31:0] slot_q    [SLOTS];
  logic [31:0] scratch_q [SCRATCH_WORDS];
  logic [31:0] rd_mux;

  xrf_decode #(.WIDX_W(WIDX_W), .SLOTS(SLOTS)) u_dec (
    .word(req_word), .sel(sel), .slot(slot_idx)
  );

  assign wr        = req_valid &&  req_write;
  assign rd        = req_valid && !req_write;
  assign ctrl_we   = wr && (sel == SEL_CTRL);
  assign ident_we  = wr && (sel == SEL_IDENT);
  assign fsr_touch = req_valid && (sel == SEL_FSR || sel == SEL_FAR);

  xrf_window u_win (
    .clk(clk), .rst_n(rst_n), .load(ctrl_we),
    .code(req_wdata[4:2]), .start(win_start)
  );

  xrf_fault u_flt (
    .clk(clk), .rst_n(rst_n),
    .cap_valid(flt_valid), .cap_addr(flt_addr), .cap_is_write(flt_is_write),
    .fsr_we(wr && sel == SEL_FSR), .far_we(wr && sel == SEL_FAR),
    .touch(fsr_touch), .wdata(req_wdata),
    .fsr_q(fsr_q), .far_q(far_q), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_INIT;
      base_q  <= 32'h0;
      tlbf_q  <= 32'h0;
      pgf_q   <= 32'h0;
      aer_q   <= AER_INIT;
      arben_q <= ARB_SET;
      ident_q <= IDENT_INIT;
    end else if (wr) begin
      case (sel)
        SEL_CTRL:  ctrl_q  <= (req_wdata & CTRL_KEEP) | CTRL_INIT;
        SEL_BASE:  base_q  <= req_wdata & BASE_KEEP;
        SEL_TLBF:  tlbf_q  <= req_wdata;
        SEL_PGF:   pgf_q   <= req_wdata;
        SEL_AER:   aer_q   <= (req_wdata & AER_KEEP) | AER_SET;
        SEL_ARBEN: arben_q <= (req_wdata & ARB_KEEP) | ARB_SET;
        SEL_IDENT: ident_q <= ident_q | (req_wdata & IDENT_KEEP);
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= 32'h0;
      else if (wr && sel == SEL_SLOT && slot_idx == SLOT_W'(g))
        slot_q[g] <= req_wdata & SLOT_KEEP;
    end
  end

  for (genvar s = 0; s < SCRATCH_WORDS; s++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scratch_q[s] <= 32'h0;
      else if (wr && sel == SEL_SCRATCH && req_word[SCR_W-1:0] == SCR_W'(s))
        scratch_q[s] <= req_wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  rd_mux = ctrl_q;
      SEL_BASE:  rd_mux = base_q;
      SEL_TLBF:  rd_mux = tlbf_q;
      SEL_PGF:   rd_mux = pgf_q;
      SEL_FSR:   rd_mux = fsr_q;
      SEL_FAR:   rd_mux = far_q;
      SEL_AER:   rd_mux = aer_q;
      SEL_SLOT:  rd_mux = slot_q[slot_idx];
      SEL_ARBEN: rd_mux = arben_q;
      SEL_IDENT: rd_mux = ident_q;
      default:   rd_mux = scratch_q[req_word[SCR_W-1:0]];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end

  assign xlat_en  = ctrl_q[0];
  assign tbl_base = base_q;
endmodule

// File: rtl/xrf_checker.sv
module xrf_checker
  import xrf_pkg::*;
#(
  parameter int WIDX_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [WIDX_W-1:0] req_word,
  input logic              rsp_valid,
  input logic              rdata0,
  input logic              flt_valid,
  input logic              irq,
  input logic              fsr_touch,
  input logic              ctrl_we,
  input logic              ident_we,
  input logic [31:0]       ident_q,
  input logic [31:0]       win_start
);
  assert_capture_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> irq);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(flt_valid));

  assert_touch_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_touch && !flt_valid) |=> !irq);

  assert_capture_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsr_touch && flt_valid) |=> irq);

  assert_window_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ($countones(~win_start + 32'h1) == 1 && win_start[23:0] == 24'h0));

  assert_ident_accum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ident_we |=> ((ident_q & $past(ident_q)) == $past(ident_q)));

  assert_read_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_aer_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_word) == WIDX_W'(IDX_AER)) |-> rdata0);
endmodule

bind xlat_regfile xrf_checker #(.WIDX_W(WIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_word(req_word), .rsp_valid(rsp_valid), .rdata0(rsp_rdata[0]),
  .flt_valid(flt_valid), .irq(irq), .fsr_touch(fsr_touch),
  .ctrl_we(ctrl_we), .ident_we(ident_we), .ident_q(ident_q),
  .win_start(win_start)
);

// File: tb/xlat_regfile_bench.sv
`timescale 1ns/1ps
module xlat_regfile_bench;
  localparam int         WW  = 12;
  localparam logic [7:0] VER = 8'h41;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [WW-1:0] req_word = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          flt_valid = 1'b0, flt_is_write = 1'b0;
  logic [31:0]   flt_addr = '0;
  logic          irq, xlat_en;
  logic [31:0]   win_start, tbl_base;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  xlat_regfile u_xlat_regfile (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_is_write(flt_is_write), .irq(irq), .xlat_en(xlat_en),
    .win_start(win_start), .tbl_base(tbl_base)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_word = WW'(idx); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = WW'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) begin
      n_bad++;
      $display("FAIL R11: rsp_valid actual 0 expected 1 (word %03h)", idx);
    end
    d = rsp_rdata;
  endtask

  task automatic rd_chk(input string tag, input int idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 xlat_en", {31'b0, xlat_en}, 32'h0);
    chk("R1 win_start", win_start, 32'h0);
    chk("R1 tbl_base", tbl_base, 32'h0);
    rd_chk("R1 ctrl", 'h000, {VER, 24'h0});
    rd_chk("R1 arben", 'h800, 32'h8);
    rd_chk("R1 fsr", 'h400, 32'h0080_0000);
    rd_chk("R1 aer", 'h402, 32'h3);
    rd_chk("R1 ident", 'hC06, 32'h2300_0000);
    rd_chk("R1 base", 'h001, 32'h0);
    rd_chk("R1 scratch", 'h123, 32'h0);
  endtask

  task automatic t_ctrl_window();
    for (int c = 0; c < 8; c++) begin
      logic [31:0] exp_w;
      exp_w = 32'h0 - (32'h1 << (24 + c));
      wr('h000, {27'h0, c[2:0], 2'b00});
      chk($sformatf("R3 window code %0d", c), win_start, exp_w);
    end
    wr('h000, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl all ones", 'h000, {VER, 24'h00001D});
    chk("R2 xlat_en set", {31'b0, xlat_en}, 32'h1);
    chk("R3 window 2GB", win_start, 32'h8000_0000);
    wr('h000, 32'h0000_0000);
    chk("R2 xlat_en clear", {31'b0, xlat_en}, 32'h0);
    chk("R3 window 16MB", win_start, 32'hFF00_0000);
  endtask

  task automatic t_masks();
    wr('h001, 32'hFFFF_FFFF);
    rd_chk("R4 base mask", 'h001, 32'h07FF_FC00);
    chk("R4 tbl_base", tbl_base, 32'h07FF_FC00);
    wr('h406, 32'hFFFF_FFFF);
    rd_chk("R4 slot mask", 'h406, 32'h0001_0003);
    rd_chk("R4 other slot untouched", 'h405, 32'h0);
    wr('h005, 32'hDEAD_BEEF);
    rd_chk("R4 tlb flush", 'h005, 32'hDEAD_BEEF);
    wr('h006, 32'h1234_5678);
    rd_chk("R4 page flush", 'h006, 32'h1234_5678);
    wr('h402, 32'h0);
    rd_chk("R5 aer zero", 'h402, 32'h1);
    wr('h402, 32'hFFFF_FFFF);
    rd_chk("R5 aer ones", 'h402, 32'h801F_000F);
    wr('h800, 32'h0);
    rd_chk("R5 arben zero", 'h800, 32'h8);
    wr('h800, 32'hFFFF_FFFF);
    rd_chk("R5 arben ones", 'h800, 32'h001F_0008);
    wr('h400, 32'h0);
    rd_chk("R6 fsr zero", 'h400, 32'h0080_0000);
    wr('h400, 32'hFFFF_FFFF);
    rd_chk("R6 fsr ones", 'h400, 32'hFF8F_FFFF);
    wr('h401, 32'hCAFE_F00D);
    rd_chk("R6 far", 'h401, 32'hCAFE_F00D);
  endtask

  task automatic t_ident();
    wr('hC06, 32'hFF00_0101);
    rd_chk("R7 ident first", 'hC06, 32'h2300_0101);
    wr('hC06, 32'h0000_1010);
    rd_chk("R7 ident accumulate", 'hC06, 32'h2300_1111);
  endtask

  task automatic fault(input logic [31:0] a, input logic w);
    @(negedge clk);
    flt_valid = 1'b1; flt_addr = a; flt_is_write = w;
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic t_fault_and_clear();
    fault(32'h0ABC_D000, 1'b0);
    chk("R8 irq after read fault", {31'b0, irq}, 32'h1);
    rd_chk("R9 other read keeps irq", 'h000, {VER, 24'h0});
    chk("R9 irq kept", {31'b0, irq}, 32'h1);
    rd_chk("R8 fsr read fault", 'h400, 32'hC086_0000);
    chk("R9 irq cleared by fsr read", {31'b0, irq}, 32'h0);
    fault(32'h0000_7000, 1'b1);
    chk("R8 irq after write fault", {31'b0, irq}, 32'h1);
    rd_chk("R8 far", 'h401, 32'h0000_7000);
    chk("R9 irq cleared by far read", {31'b0, irq}, 32'h0);
    rd_chk("R8 fsr write fault", 'h400, 32'hC082_0000);
    fault(32'h0000_9000, 1'b1);
    wr('h401, 32'h5555_0000);
    chk("R9 irq cleared by far write", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_priority();
    @(negedge clk);
    flt_valid = 1'b1; flt_addr = 32'h00F0_0000; flt_is_write = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_word = WW'('h400); req_wdata = 32'h0;
    @(negedge clk);
    flt_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    chk("R10 irq held vs fsr write", {31'b0, irq}, 32'h1);
    rd_chk("R10 fsr capture wins", 'h400, 32'hC086_0000);
    chk("R9 cleared after", {31'b0, irq}, 32'h0);
    @(negedge clk);
    flt_valid = 1'b1; flt_addr = 32'h0011_1000; flt_is_write = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_word = WW'('h401);
    @(negedge clk);
    flt_valid = 1'b0; req_valid = 1'b0;
    chk("R10 irq held vs far read", {31'b0, irq}, 32'h1);
    rd_chk("R10 far capture value", 'h401, 32'h0011_1000);
  endtask

  task automatic t_scratch();
    wr('h010, 32'hA5A5_0F0F);
    rd_chk("R11 scratch", 'h010, 32'hA5A5_0F0F);
    rd_chk("R11 scratch alias", 'h020, 32'hA5A5_0F0F);
    rd_chk("R11 ctrl not scratch", 'h000, {VER, 24'h0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_window();
    t_masks();
    t_ident();
    t_fault_and_clear();
    t_priority();
    t_scratch();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule